// File: doc/BRIEF.md
# CAN Bit Timing Resynchronizer

This block derives the bit timing of a CAN node from the system clock. A prescaler divides the clock into time quanta. A segment sequencer then steps each bit through four parts: one synchronization quantum, a propagation segment, a first phase segment and a second phase segment. The receive line is sampled at the boundary between the two phase segments. A strobe marks the first clock of every bit, and that clock is the point where a transmitter launches its next bit.

The receive line enters already synchronized to the clock. While the bus-idle input is high, any recessive-to-dominant transition restarts the bit timing at once. This is hard synchronization. While the bus is busy, the first such transition in a bit measures the phase error in whole quanta:

- If the edge falls after the sync quantum and before the sample point, the first phase segment is lengthened.
- If the edge falls after the sample point, the second phase segment is shortened.

In both cases the correction is limited to the configured jump width. If the edge falls in the second phase segment and its error is within the jump width, the whole error is removed and a new bit starts at once. Bit stuffing and frame decoding belong to the logic that consumes the strobes.

Top module: `cbt_bit_timer`

## Requirements
- R1: The quantum tick `tq_tick_o` is a one-clock pulse. When no restart occurs, it repeats every 2·(`brp_i`+1) clocks.
- R2: Segment lengths are the field value plus one quantum: P = `prop_i`+1, A = `ph1_i`+1, B = `ph2_i`+1. The jump width is S = `sjw_i`+1. With no resynchronization, a bit lasts 1+P+A+B quanta. `bit_start_o` is high on the first clock of the sync quantum. `sample_o` is high on the last clock of the first phase segment, which is Q·(1+P+A)−1 clocks after `bit_start_o`, where Q is the quantum length.
- R3: A falling edge of `rx_i` in a clock where `idle_i` is high causes `bit_start_o` on the next clock. Timing then continues with the nominal layout.
- R4: With `idle_i` low, suppose the first falling edge in a bit lies in quantum k of the bit (sync quantum = 0) with 1 ≤ k ≤ P+A. Then the first phase segment grows by min(k, S) quanta, which delays both the sample point and the next bit start by that amount.
- R5: With `idle_i` low, suppose the first falling edge lies in quantum k of the second phase segment and the error e = (1+P+A+B)−k exceeds S. Then the second phase segment is shortened by S quanta.
- R6: In the situation of R5, if e ≤ S, `bit_start_o` is high on the clock right after the edge clock. This cancels the whole error.
- R7: Only the first falling edge in a bit is evaluated. An edge in the sync quantum uses up that chance and changes nothing. Later falling edges and all rising edges have no effect.
- R8: `bit_o` takes the value of `rx_i` from the clock of `sample_o` and shows it from the next clock. It holds that value until the next sample.
- R9: During reset, `tq_tick_o`, `sample_o` and `bit_start_o` are low and `bit_o` is high (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronized receive line, 0 = dominant |
| idle_i | input | 1 | Bus idle; falling edges cause hard synchronization |
| brp_i | input | 6 | Prescaler field; quantum = 2·(brp_i+1) clocks |
| prop_i | input | 3 | Propagation segment length minus one |
| ph1_i | input | 3 | First phase segment length minus one |
| ph2_i | input | 3 | Second phase segment length minus one (at least 1) |
| sjw_i | input | 2 | Jump width minus one |
| tq_tick_o | output | 1 | Pulse on the last clock of each quantum |
| sample_o | output | 1 | Sample-point strobe |
| bit_o | output | 1 | Value of rx_i at the latest sample point |
| bit_start_o | output | 1 | First clock of a bit (transmit point) |

## Verification
A corrupted segment counter or quantum counter moves `sample_o` and `bit_start_o` by whole quanta. The shift shows up within the same bit it happens in. A stale extension or shortening value leaks into the following bit and makes that bit too long or too short, so it is seen one bit time later. A failure to block second edges shows up as double corrections, and those are visible as extra quanta in the affected bit. The bench therefore measures clock distances between these strobes and compares them with distances computed from the segment fields.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  localparam int CNT_W = BRP_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_lim;

  // Quantum is 2*(brp+1) clocks, so the terminal count is 2*brp+1.
  assign cnt_lim = {brp, 1'b1};
  assign tick    = (cnt_q == cnt_lim);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: a quantum is at least two clocks, ticks never come back to back
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cbt_rx_tracker.sv
module cbt_rx_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic sample,
  output logic fall,
  output logic bit_val
);
  logic rx_q, bit_q, bit_d;

  assign fall    = rx_q & ~rx_i;
  assign bit_val = bit_q;

  always_comb begin
    bit_d = bit_q;
    if (sample) bit_d = rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b1;
      bit_q <= 1'b1;
    end else begin
      rx_q  <= rx_i;
      bit_q <= bit_d;
    end
  end

  // R8: sampled value changes only after a sample strobe
  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(bit_q));
  a_r8_bit_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (bit_q == $past(rx_i)));
endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
  import cbt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fall,
  input  logic             idle,
  input  logic [SEG_W-1:0] prop_cfg,
  input  logic [SEG_W-1:0] ph1_cfg,
  input  logic [SEG_W-1:0] ph2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  output logic             restart,
  output logic             sample,
  output logic             bit_start
);
  localparam int LEN_W = SEG_W + 2;

  seg_e             seg_q, seg_d;
  logic [LEN_W-1:0] qidx_q, qidx_d;
  logic [LEN_W-1:0] ext_q, ext_d, sub_q, sub_d;
  logic             done_q, done_d, start_q, start_d;

  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
  logic [LEN_W-1:0] pos_err, neg_err, pos_corr, ext_now, sub_now, seg_len;
  logic             resync_ok, pos_hit, neg_hit, neg_full, last_q;

  // configured lengths
  always_comb begin
    prop_len = LEN_W'(prop_cfg) + LEN_W'(1);
    ph1_len  = LEN_W'(ph1_cfg)  + LEN_W'(1);
    ph2_len  = LEN_W'(ph2_cfg)  + LEN_W'(1);
    sjw_len  = LEN_W'(sjw_cfg)  + LEN_W'(1);
  end

  // phase error in quanta
  always_comb begin
    case (seg_q)
      SEG_PROP: pos_err = qidx_q + LEN_W'(1);
      SEG_PH1:  pos_err = prop_len + qidx_q + LEN_W'(1);
      default:  pos_err = '0;
    endcase
    neg_err   = ph2_len - qidx_q;
    resync_ok = fall & ~idle & ~done_q;
    pos_hit   = resync_ok & ((seg_q == SEG_PROP) | (seg_q == SEG_PH1));
    neg_hit   = resync_ok & (seg_q == SEG_PH2);
    neg_full  = neg_hit & (neg_err <= sjw_len);
    restart   = (fall & idle) | neg_full;
    pos_corr  = (pos_err < sjw_len) ? pos_err : sjw_len;
    ext_now   = pos_hit ? pos_corr : ext_q;
    sub_now   = (neg_hit & ~neg_full) ? sjw_len : sub_q;
  end

  // current segment length including corrections of this bit
  always_comb begin
    case (seg_q)
      SEG_SYNC: seg_len = LEN_W'(1);
      SEG_PROP: seg_len = prop_len;
      SEG_PH1:  seg_len = ph1_len + ext_now;
      default:  seg_len = ph2_len - sub_now;
    endcase
    last_q = (qidx_q == (seg_len - LEN_W'(1)));
  end

  assign sample    = tick & (seg_q == SEG_PH1) & last_q;
  assign bit_start = start_q;

  // next state
  always_comb begin
    seg_d   = seg_q;
    qidx_d  = qidx_q;
    ext_d   = ext_now;
    sub_d   = sub_now;
    done_d  = done_q | resync_ok;
    start_d = 1'b0;
    if (restart) begin
      seg_d   = SEG_SYNC;
      qidx_d  = '0;
      ext_d   = '0;
      sub_d   = '0;
      done_d  = 1'b0;
      start_d = 1'b1;
    end else if (tick) begin
      if (last_q) begin
        qidx_d = '0;
        case (seg_q)
          SEG_SYNC: seg_d = SEG_PROP;
          SEG_PROP: seg_d = SEG_PH1;
          SEG_PH1:  seg_d = SEG_PH2;
          default: begin
            seg_d   = SEG_SYNC;
            ext_d   = '0;
            sub_d   = '0;
            done_d  = 1'b0;
            start_d = 1'b1;
          end
        endcase
      end else begin
        qidx_d = qidx_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_SYNC;
      qidx_q  <= '0;
      ext_q   <= '0;
      sub_q   <= '0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      qidx_q  <= qidx_d;
      ext_q   <= ext_d;
      sub_q   <= sub_d;
      done_q  <= done_d;
      start_q <= start_d;
    end
  end

  // R3: an idle-bus falling edge restarts the bit on the next clock
  a_r3_hard_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && idle) |=> (bit_start && seg_q == SEG_SYNC && qidx_q == '0));
  // R6: small negative error ends the bit immediately
  a_r6_full_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    neg_full |=> (bit_start && seg_q == SEG_SYNC));
  // R4: lengthening never exceeds the jump width
  a_r4_ext_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= sjw_len);
  // R5: shortening is either absent or exactly the jump width
  a_r5_sub_values: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q == '0) || (sub_q == sjw_len));
  // R7: after the single evaluated edge the corrections stay put until a new bit
  a_r7_one_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (bit_start || ($stable(ext_q) && $stable(sub_q))));
  // R2: the sample point never coincides with a bit start
  a_r2_start_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> !sample);
endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             idle_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ph1_i,
  input  logic [SEG_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             tq_tick_o,
  output logic             sample_o,
  output logic             bit_o,
  output logic             bit_start_o
);
  logic tick, restart, fall, sample;

  cbt_quantum_gen #(.BRP_W(BRP_W)) u_qgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .brp     (brp_i),
    .tick    (tick)
  );

  cbt_rx_tracker u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_i    (rx_i),
    .sample  (sample),
    .fall    (fall),
    .bit_val (bit_o)
  );

  cbt_seg_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fall      (fall),
    .idle      (idle_i),
    .prop_cfg  (prop_i),
    .ph1_cfg   (ph1_i),
    .ph2_cfg   (ph2_i),
    .sjw_cfg   (sjw_i),
    .restart   (restart),
    .sample    (sample),
    .bit_start (bit_start_o)
  );

  assign tq_tick_o = tick;
  assign sample_o  = sample;
endmodule

// File: tb/cbt_bit_timer_tb.sv
module cbt_bit_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K_NONE = 0, K_POS = 1, K_NEG = 2, K_HARD = 3, K_DBL = 4;

  logic       clk, rst_n, rx_i, idle_i;
  logic [5:0] brp_i;
  logic [2:0] prop_i, ph1_i, ph2_i;
  logic [1:0] sjw_i;
  logic       tq_tick_o, sample_o, bit_o, bit_start_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  cbt_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .idle_i(idle_i),
    .brp_i(brp_i), .prop_i(prop_i), .ph1_i(ph1_i), .ph2_i(ph2_i), .sjw_i(sjw_i),
    .tq_tick_o(tq_tick_o), .sample_o(sample_o), .bit_o(bit_o), .bit_start_o(bit_start_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int qlen(int b);
    return 2 * (b + 1);
  endfunction

  function automatic int imin(int x, int y);
    return (x < y) ? x : y;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_start(output int t);
    do @(negedge clk); while (!bit_start_o);
    t = cyc;
  endtask

  task automatic wait_sample(output int t);
    do @(negedge clk); while (!sample_o);
    t = cyc;
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!tq_tick_o);
    t = cyc;
  endtask

  task automatic at_cycle(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic setup(int b, int p, int a, int c2, int s);
    @(negedge clk);
    rst_n  = 1'b0;
    idle_i = 1'b0;
    rx_i   = 1'b1;
    brp_i  = 6'(b);
    prop_i = 3'(p);
    ph1_i  = 3'(a);
    ph2_i  = 3'(c2);
    sjw_i  = 2'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(int b, int p, int a, int c2, int s, int kind, int k, int off, int lvl);
    int P, A, B, S, Q, N, m, e, t0, t1, ts, c;
    P = p + 1; A = a + 1; B = c2 + 1; S = s + 1;
    Q = qlen(b); N = 1 + P + A + B;
    setup(b, p, a, c2, s);
    wait_start(t0);
    case (kind)
      K_NONE: begin
        if (lvl == 0) rx_i = 1'b0;  // edge inside the sync quantum
        wait_sample(ts);
        chk(ts - t0 == Q*(1+P+A) - 1, "R2 sample offset", ts - t0, Q*(1+P+A) - 1);
        @(negedge clk);
        chk(bit_o == lvl[0], "R8 sampled bit", int'(bit_o), lvl);
        rx_i = 1'b1;
        wait_start(t1);
        if (lvl == 0) chk(t1 - t0 == Q*N, "R7 sync-quantum edge no effect", t1 - t0, Q*N);
        else          chk(t1 - t0 == Q*N, "R2 bit length", t1 - t0, Q*N);
      end
      K_POS: begin
        at_cycle(t0 + Q*k + off);
        rx_i = 1'b0;
        m = imin(k, S);
        wait_sample(ts);
        chk(ts - t0 == Q*(1+P+A+m) - 1, "R4 sample delayed", ts - t0, Q*(1+P+A+m) - 1);
        rx_i = 1'b1;
        wait_start(t1);
        chk(t1 - t0 == Q*(N+m), "R4 bit lengthened", t1 - t0, Q*(N+m));
      end
      K_NEG: begin
        wait_sample(ts);
        chk(ts - t0 == Q*(1+P+A) - 1, "R2 sample offset", ts - t0, Q*(1+P+A) - 1);
        at_cycle(t0 + Q*k + off);
        rx_i = 1'b0;
        c = cyc;
        e = N - k;
        wait_start(t1);
        rx_i = 1'b1;
        if (e <= S) chk(t1 == c + 1, "R6 full cancel restart", t1 - c, 1);
        else        chk(t1 - t0 == Q*(N-S), "R5 bit shortened", t1 - t0, Q*(N-S));
      end
      K_HARD: begin
        idle_i = 1'b1;
        at_cycle(t0 + Q*k + off);
        rx_i = 1'b0;
        c = cyc;
        wait_start(t1);
        chk(t1 == c + 1, "R3 hard sync start", t1 - c, 1);
        rx_i = 1'b1;
        wait_sample(ts);
        chk(ts - t1 == Q*(1+P+A) - 1, "R3 sample after hard sync", ts - t1, Q*(1+P+A) - 1);
        idle_i = 1'b0;
      end
      default: begin  // two falling edges in one bit: only the first counts
        at_cycle(t0 + Q);
        rx_i = 1'b0;
        @(negedge clk);
        rx_i = 1'b1;
        at_cycle(t0 + Q*k + off);
        rx_i = 1'b0;
        m = imin(1, S);
        wait_sample(ts);
        chk(ts - t0 == Q*(1+P+A+m) - 1, "R7 second edge ignored (sample)", ts - t0, Q*(1+P+A+m) - 1);
        rx_i = 1'b1;
        wait_start(t1);
        chk(t1 - t0 == Q*(N+m), "R7 second edge ignored (length)", t1 - t0, Q*(N+m));
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int t_a, t_b, b, p, a, c2, s, kind, k, off, lvl, P, A, B, N, Q;
    rst_n = 1'b0; rx_i = 1'b1; idle_i = 1'b0;
    brp_i = '0; prop_i = '0; ph1_i = '0; ph2_i = 3'd1; sjw_i = '0;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R9: reset values
    chk(tq_tick_o == 1'b0, "R9 tick in reset", int'(tq_tick_o), 0);
    chk(sample_o == 1'b0, "R9 sample in reset", int'(sample_o), 0);
    chk(bit_start_o == 1'b0, "R9 start in reset", int'(bit_start_o), 0);
    chk(bit_o == 1'b1, "R9 bit recessive in reset", int'(bit_o), 1);

    // R1: tick spacing for two prescaler settings
    setup(0, 1, 1, 1, 0);
    wait_tick(t_a); wait_tick(t_b);
    chk(t_b - t_a == 2, "R1 tick period brp=0", t_b - t_a, 2);
    setup(5, 1, 1, 1, 0);
    wait_tick(t_a); wait_tick(t_b);
    chk(t_b - t_a == 12, "R1 tick period brp=5", t_b - t_a, 12);

    // directed corners
    run_case(63, 0, 0, 1, 0, K_NONE, 0, 0, 1);          // largest quantum
    run_case(0, 2, 1, 3, 1, K_NEG, 10 - 2, 0, 0);       // e == S -> R6
    run_case(0, 2, 1, 3, 1, K_NEG, 10 - 3, 1, 0);       // e == S+1 -> R5
    run_case(1, 0, 0, 1, 3, K_NEG, 5 - 2, 3, 0);        // shortest PH2, wide SJW
    run_case(1, 7, 7, 1, 0, K_POS, 16, 0, 0);           // e far above S
    run_case(1, 3, 3, 2, 3, K_POS, 2, 0, 0);            // e below S
    run_case(2, 1, 1, 1, 0, K_HARD, 0, 0, 0);           // hard sync in sync quantum
    run_case(0, 4, 2, 2, 2, K_NONE, 0, 0, 0);           // sync-quantum edge, low bit
    run_case(1, 2, 3, 2, 1, K_DBL, 4, 1, 0);

    // constrained random
    for (int i = 0; i < 24; i++) begin
      b = int'($urandom % 8); p = int'($urandom % 8); a = int'($urandom % 8);
      c2 = 1 + int'($urandom % 7); s = int'($urandom % 4);
      kind = int'($urandom % 5); lvl = int'($urandom % 2);
      P = p + 1; A = a + 1; B = c2 + 1; N = 1 + P + A + B; Q = qlen(b);
      off = int'($urandom % Q);
      case (kind)
        K_POS:   k = 1 + int'($urandom % (P + A));
        K_NEG:   k = 1 + P + A + int'($urandom % B);
        K_HARD:  k = int'($urandom % N);
        K_DBL:   k = 2 + int'($urandom % (P + A - 1));
        default: k = 0;
      endcase
      run_case(b, p, a, c2, s, kind, k, off, lvl);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule